// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block keeps a small set of setup registers (a configuration word, a base-address word and a 48-bit station address) filled from a serial EEPROM that uses a microwire-style command protocol. When reset is released it fetches those words without any help from software. Afterwards the CPU can ask it to fetch them again, or to write the live values back to the EEPROM. A static strap input chooses which of eight configuration/base slots in the EEPROM is used.

The CPU sees eight 16-bit registers on a simple write-enable/address/data port, with a combinational read path. Writing the control register starts an operation. Software then polls that register until both operation bits read low. While an operation is running, every other CPU write is dropped. A direct-access mode uses a general-purpose register and a pointer register to read or write one EEPROM word at any address, and this mode leaves the live setup untouched.

On the serial side the block drives a shift clock, a chip select that frames each command, and a data line. It samples the EEPROM's data output. Each write command is preceded by its own write-enable command and followed by a fixed wait during which the chip select stays low.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, control reads 0x0003 and cfg_o reads zero. After reset is released, the block loads cfg_o from EEPROM word strap*4, base_o from word strap*4+1, and mac_o[15:0], [31:16], [47:32] from words 0x20, 0x21, 0x22, with no CPU access needed.
- R2: Framing. Each command runs with chip select high. It sends a 1 start bit, a 2-bit opcode (read 10, write 01, write-enable 00 with address 11xxxx) and a 6-bit address, all MSB first. The data line changes only while the shift clock is low, and the EEPROM samples on the rising edge. Read data is 16 bits, MSB first, taken on the 16 rising edges that follow the address bits, with no dummy bit.
- R3: Every shift clock low phase and high phase lasts SK_HALF cycles. Chip select stays low for at least SK_HALF cycles between commands.
- R4: Register map: 0 control, 1 configuration, 2 base, 3/4/5 address words, 6 general-purpose, 7 pointer (low 6 bits used). Control bit 0 starts a reload and bit 1 starts a store. Both read 1 from the cycle after the starting write until the operation ends, and read 0 when idle.
- R5: While an operation runs, CPU writes to every register, including control, have no effect.
- R6: Writing control with bit 0 set and bit 2 clear reloads all five setup words from the slot that the strap selects at that time.
- R7: A store with bit 2 clear writes configuration, base and the three address words back to their EEPROM words. Each write command is preceded by one write-enable command and followed by at least WR_WAIT cycles with chip select low.
- R8: A reload with bit 2 set reads only the EEPROM word at the pointer into the general-purpose register, and leaves cfg_o, base_o and mac_o unchanged. It keeps the block busy for exactly 2+51*SK_HALF cycles after the write edge.
- R9: A store with bit 2 set writes only the general-purpose register, to the EEPROM word at the pointer.
- R10: When bits 0 and 1 are both written as 1, a reload is performed and nothing is written.
- R11: Control bit 2 reads back the last value written to it while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_sel_i | input | SEL_W | Slot select strap |
| reg_we_i | input | 1 | CPU register write strobe |
| reg_addr_i | input | 3 | CPU register address |
| reg_wdata_i | input | DW | CPU write data |
| reg_rdata_o | output | DW | CPU read data (combinational) |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_cs_o | output | 1 | EEPROM chip select / command frame |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| cfg_o | output | DW | Live configuration word |
| base_o | output | DW | Live base-address word |
| mac_o | output | 3*DW | Live station address words |

## Verification
The busy flag appears in control one cycle after the starting write edge, and the bench reads it at the next falling clock edge. A single-word read is due exactly 2+(2*25+1)*SK_HALF cycles after its write edge, so the bench counts the falling edges on which busy is still set and compares that count with the figure. Multi-word operations are allowed to run to completion by polling control, and register and EEPROM contents are compared only after busy has cleared. Shift clock phase lengths, gaps between frames and the post-write waits are measured in whole clock cycles by an EEPROM model in the bench.

// File: rtl/cfg_ee_pkg.sv
package cfg_ee_pkg;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_EN = 2'b00;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] IDX_GP  = 3'd5;  // word index of general-purpose reg
  localparam logic [2:0] IDX_TOP = 3'd4;  // last word of a full transfer

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_GAP} sh_st_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_EN, SQ_XFER, SQ_WAIT} sq_st_e;
endpackage

// File: rtl/ee_shift.sv
module ee_shift
  import cfg_ee_pkg::*;
#(
  parameter int FW   = 25,
  parameter int DW   = 16,
  parameter int HALF = 400,
  localparam int NW  = $clog2(FW + 1),
  localparam int CW  = $clog2(HALF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [NW-1:0] nbits_i,
  input  logic [FW-1:0] frame_i,
  input  logic          do_i,
  output logic          sk_o,
  output logic          cs_o,
  output logic          di_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  sh_st_e        st_q;
  logic [CW-1:0] div_q;
  logic [NW-1:0] cnt_q, nb_q;
  logic [FW-1:0] sr_q;
  logic [DW-1:0] rx_q;
  logic          sk_q, cs_q, done_q;

  wire half_end = (div_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      div_q  <= '0;
      cnt_q  <= '0;
      nb_q   <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
      sk_q   <= 1'b0;
      cs_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      div_q  <= half_end ? '0 : div_q + 1'b1;
      unique case (st_q)
        SH_IDLE: begin
          div_q <= '0;
          if (go_i) begin
            cs_q  <= 1'b1;
            sr_q  <= frame_i;
            nb_q  <= nbits_i;
            cnt_q <= '0;
            st_q  <= SH_LOW;
          end
        end
        SH_LOW: if (half_end) begin
          sk_q <= 1'b1;
          rx_q <= {rx_q[DW-2:0], do_i};
          st_q <= SH_HIGH;
        end
        SH_HIGH: if (half_end) begin
          sk_q <= 1'b0;
          if (cnt_q == nb_q - 1'b1) begin
            cs_q <= 1'b0;
            st_q <= SH_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            sr_q  <= {sr_q[FW-2:0], 1'b0};
            st_q  <= SH_LOW;
          end
        end
        SH_GAP: if (half_end) begin
          done_q <= 1'b1;
          st_q   <= SH_IDLE;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign sk_o   = sk_q;
  assign cs_o   = cs_q;
  assign di_o   = sr_q[FW-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import cfg_ee_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int WR_WAIT = 2000000,
  parameter int IA_BASE = 32,
  localparam int FW     = 3 + AW + DW,
  localparam int NW     = $clog2(FW + 1),
  localparam int WCW    = $clog2(WR_WAIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic             single_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic             sh_done_i,
  output logic             busy_o,
  output logic             go_o,
  output logic [NW-1:0]    nbits_o,
  output logic [FW-1:0]    frame_o,
  output logic [2:0]       idx_o,
  output logic             ld_o
);
  sq_st_e         st_q;
  logic           go_q, wr_q, full_q;
  logic [2:0]     idx_q;
  logic [WCW-1:0] wcnt_q;
  logic [AW-1:0]  wa;

  wire last = !full_q || (idx_q == IDX_TOP);

  always_comb begin
    if (idx_q == IDX_GP)    wa = ptr_i;
    else if (idx_q < 3'd2)  wa = AW'({strap_i, idx_q[1:0]});
    else                    wa = AW'(IA_BASE) + AW'(idx_q - 3'd2);
  end

  always_comb begin
    if (st_q == SQ_EN) begin
      frame_o = {1'b1, OP_EN, 2'b11, {(AW-2){1'b0}}, {DW{1'b0}}};
      nbits_o = NW'(3 + AW);
    end else begin
      frame_o = {1'b1, (wr_q ? OP_WR : OP_RD), wa, (wr_q ? st_data_i : {DW{1'b0}})};
      nbits_o = NW'(FW);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_XFER;  // boot-time reload
      go_q   <= 1'b1;
      wr_q   <= 1'b0;
      full_q <= 1'b1;
      idx_q  <= '0;
      wcnt_q <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (rd_req_i || wr_req_i) begin
            st_q   <= rd_req_i ? SQ_XFER : SQ_EN;
            wr_q   <= !rd_req_i;
            go_q   <= 1'b1;
            full_q <= !single_i;
            idx_q  <= single_i ? IDX_GP : 3'd0;
          end
        end
        SQ_EN: if (sh_done_i) begin
          st_q <= SQ_XFER;
          go_q <= 1'b1;
        end
        SQ_XFER: if (sh_done_i) begin
          if (wr_q) begin
            st_q   <= SQ_WAIT;
            wcnt_q <= '0;
          end else if (last) begin
            st_q <= SQ_IDLE;
          end else begin
            idx_q <= idx_q + 3'd1;
            go_q  <= 1'b1;
          end
        end
        SQ_WAIT: begin
          if (wcnt_q == WCW'(WR_WAIT - 1)) begin
            if (last) st_q <= SQ_IDLE;
            else begin
              idx_q <= idx_q + 3'd1;
              st_q  <= SQ_EN;
              go_q  <= 1'b1;
            end
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != SQ_IDLE);
  assign go_o   = go_q;
  assign idx_o  = idx_q;
  assign ld_o   = (st_q == SQ_XFER) && sh_done_i && !wr_q;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_ee_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  input  logic              ld_i,
  input  logic [2:0]        ld_idx_i,
  input  logic [DW-1:0]     ld_data_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic              single_o,
  output logic [7:1][DW-1:0] regs_o
);
  logic [7:1][DW-1:0] reg_q;
  logic               sel_q;

  wire acc     = we_i && !busy_i;
  wire ctrl_wr = acc && (addr_i == RA_CTRL);

  assign rd_req_o = ctrl_wr && wdata_i[0];
  assign wr_req_o = ctrl_wr && !wdata_i[0] && wdata_i[1];
  assign single_o = wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      sel_q <= 1'b0;
    end else begin
      if (acc) begin
        if (addr_i == RA_CTRL) sel_q <= wdata_i[2];
        else                   reg_q[addr_i] <= wdata_i;
      end
      if (ld_i) reg_q[ld_idx_i + 3'd1] <= ld_data_i;
    end
  end

  always_comb begin
    if (addr_i == RA_CTRL) rdata_o = {{(DW-3){1'b0}}, sel_q, busy_i, busy_i};
    else                   rdata_o = reg_q[addr_i];
  end

  assign regs_o = reg_q;
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_ee_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int SK_HALF = 400,
  parameter int WR_WAIT = 2000000,
  parameter int IA_BASE = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] strap_sel_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             ee_sk_o,
  output logic             ee_cs_o,
  output logic             ee_di_o,
  input  logic             ee_do_i,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    base_o,
  output logic [3*DW-1:0]  mac_o
);
  localparam int FW = 3 + AW + DW;
  localparam int NW = $clog2(FW + 1);

  logic               busy, go, sh_done, ld, rd_req, wr_req, single;
  logic [NW-1:0]      nbits;
  logic [FW-1:0]      frame;
  logic [2:0]         idx;
  logic [DW-1:0]      rx;
  logic [7:1][DW-1:0] regs;

  cfg_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .ld_i(ld), .ld_idx_i(idx), .ld_data_i(rx),
    .rdata_o(reg_rdata_o), .rd_req_o(rd_req), .wr_req_o(wr_req),
    .single_o(single), .regs_o(regs)
  );

  ee_seq #(.SEL_W(SEL_W), .AW(AW), .DW(DW), .WR_WAIT(WR_WAIT), .IA_BASE(IA_BASE)) u_seq (
    .clk_i, .rst_ni,
    .strap_i(strap_sel_i), .rd_req_i(rd_req), .wr_req_i(wr_req), .single_i(single),
    .ptr_i(regs[7][AW-1:0]), .st_data_i(regs[idx + 3'd1]), .sh_done_i(sh_done),
    .busy_o(busy), .go_o(go), .nbits_o(nbits), .frame_o(frame), .idx_o(idx), .ld_o(ld)
  );

  ee_shift #(.FW(FW), .DW(DW), .HALF(SK_HALF)) u_shift (
    .clk_i, .rst_ni,
    .go_i(go), .nbits_i(nbits), .frame_i(frame), .do_i(ee_do_i),
    .sk_o(ee_sk_o), .cs_o(ee_cs_o), .di_o(ee_di_o), .done_o(sh_done), .rx_o(rx)
  );

  assign cfg_o  = regs[1];
  assign base_o = regs[2];
  assign mac_o  = {regs[5], regs[4], regs[3]};
endmodule

// File: rtl/cfg_eeprom_loader_chk.sv
module cfg_eeprom_loader_chk #(
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_i,
  input logic            cs_i,
  input logic            sk_i,
  input logic            di_i,
  input logic            we_i,
  input logic [2:0]      addr_i,
  input logic [DW-1:0]   rdata_i,
  input logic [DW-1:0]   cfg_i,
  input logic [DW-1:0]   base_i,
  input logic [3*DW-1:0] mac_i
);
  AST_CS_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |-> busy_i);  // R4
  AST_CTRL_HIGH_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && addr_i == 3'd0 |-> rdata_i[1:0] == 2'b11);  // R4
  AST_SK_INSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_i |-> cs_i);  // R2
  AST_DI_HOLD_SK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_i && $past(sk_i) |-> $stable(di_i));  // R2
  AST_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && we_i |=> $stable(cfg_i) && $stable(base_i) && $stable(mac_i));  // R5
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .cs_i(ee_cs_o), .sk_i(ee_sk_o),
  .di_i(ee_di_o), .we_i(reg_we_i), .addr_i(reg_addr_i), .rdata_i(reg_rdata_o),
  .cfg_i(cfg_o), .base_i(base_o), .mac_i(mac_o)
);

// File: tb/sim_cfg_eeprom_loader.sv
`timescale 1ns/1ps
module sim_cfg_eeprom_loader;
  localparam int H = 2;
  localparam int W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  strap = 3'd5;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic        do_r = 1'b0;
  wire  [15:0] rdata, cfg, base;
  wire  [47:0] mac;
  wire         sk, cs, di;

  cfg_eeprom_loader #(.SK_HALF(H), .WR_WAIT(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_sel_i(strap), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ee_sk_o(sk), .ee_cs_o(cs), .ee_di_o(di),
    .ee_do_i(do_r), .cfg_o(cfg), .base_o(base), .mac_o(mac)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // EEPROM model
  logic [15:0] mem [64];
  int bitn = 0, n_en = 0, n_wr = 0, bad_wr = 0, bad_start = 0;
  logic [8:0]  cmd = '0;
  logic [15:0] wsh = '0;
  bit wen = 0, after_wr = 0;

  always @(posedge cs) bitn = 0;
  always @(posedge sk) begin
    if (cs) begin
      if (bitn < 9) begin
        cmd = {cmd[7:0], di};
        if (bitn == 8) begin
          if (!cmd[8]) bad_start++;
          if (cmd[7:6] == 2'b00 && cmd[5:4] == 2'b11) begin wen = 1; n_en++; end
        end
      end else if (cmd[7:6] == 2'b01) begin
        wsh = {wsh[14:0], di};
        if (bitn == 24) begin
          if (wen) begin mem[cmd[5:0]] = wsh; n_wr++; wen = 0; after_wr = 1; end
          else bad_wr++;
        end
      end
      bitn++;
    end
  end
  always @(negedge sk)
    if (cs && cmd[7:6] == 2'b10 && bitn >= 9 && bitn < 25) do_r = mem[cmd[5:0]][24-bitn];

  // serial timing monitor
  int sk_run = 0, lo_run = 1000, sk_err = 0, gap_err = 0, wait_err = 0, n_phase = 0, n_wgap = 0;
  logic p_cs = 0, p_sk = 0;
  always @(negedge clk) begin
    if (cs && !p_cs) begin
      if (lo_run < H) gap_err++;
      if (after_wr) begin n_wgap++; if (lo_run < W) wait_err++; after_wr = 0; end
      sk_run = 1;
    end else if (cs) begin
      if (sk == p_sk) sk_run++;
      else begin if (sk_run != H) sk_err++; n_phase++; sk_run = 1; end
    end else if (p_cs) begin
      if (sk_run != H) sk_err++;
      n_phase++;
    end
    lo_run = cs ? 0 : lo_run + 1;
    p_cs = cs; p_sk = sk;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog act=%0d exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0; addr = 3'd0; #1;
    while (rdata[0] && n < 5000) begin n++; @(negedge clk); #1; end
  endtask

  task automatic chk_full(input string tag);
    int s;
    s = {strap, 2'b00};
    chk(cfg == mem[s], {tag, " cfg"}, cfg, mem[s]);
    chk(base == mem[s+1], {tag, " base"}, base, mem[s+1]);
    chk(mac == {mem[34], mem[33], mem[32]}, {tag, " mac"}, mac, {mem[34], mem[33], mem[32]});
  endtask

  initial begin
    logic [15:0] v, c0, g;
    logic [5:0]  p;
    int n, e0, w0, s;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    repeat (4) @(negedge clk);
    #1;
    chk(rdata == 16'h0003, "R1 ctrl in reset", rdata, 16'h0003);
    chk(cfg == 16'h0, "R1 cfg in reset", cfg, 0);
    rst_n = 1;
    wait_idle(n);
    chk(n < 2000, "R1 boot finishes", n, 2000);
    chk_full("R1 boot load");
    rd_reg(3'd0, v);
    chk(v == 16'h0, "R4 idle ctrl", v, 0);

    for (int k = 0; k < 4; k++) begin  // R6
      strap = 3'($urandom);
      mem[{strap, 2'b00}] = 16'($urandom);
      mem[32 + k % 3] = 16'($urandom);
      wr_reg(3'd0, 16'h0001);
      rd_reg(3'd0, v);
      chk(v[1:0] == 2'b11, "R4 busy readback", v, 3);
      wait_idle(n);
      chk_full("R6 reload");
    end

    // R5: writes during an operation are dropped
    wr_reg(3'd6, 16'hAAAA);
    s = {strap, 2'b00};
    mem[s] = ~16'h1234;
    wr_reg(3'd0, 16'h0001);
    wr_reg(3'd1, 16'h1234);
    wr_reg(3'd6, 16'h5555);
    wr_reg(3'd0, 16'h0004);
    wait_idle(n);
    chk(cfg == mem[s], "R5 cfg write dropped", cfg, mem[s]);
    rd_reg(3'd6, v);
    chk(v == 16'hAAAA, "R5 gp write dropped", v, 16'hAAAA);
    rd_reg(3'd0, v);
    chk(v == 16'h0, "R5 ctrl write dropped", v, 0);

    for (int k = 0; k < 4; k++) begin  // R8
      p = 6'($urandom);
      c0 = cfg;
      wr_reg(3'd7, 16'(p));
      wr_reg(3'd0, 16'h0005);
      wait_idle(n);
      chk(n == 2 + 51 * H, "R8 single read busy cycles", n, 2 + 51 * H);
      rd_reg(3'd6, v);
      chk(v == mem[p], "R8 gp from pointer", v, mem[p]);
      chk(cfg == c0, "R8 cfg untouched", cfg, c0);
    end

    for (int k = 0; k < 3; k++) begin  // R9
      p = 6'($urandom);
      g = 16'($urandom);
      e0 = n_en; w0 = n_wr;
      wr_reg(3'd6, g);
      wr_reg(3'd7, 16'(p));
      wr_reg(3'd0, 16'h0006);
      wait_idle(n);
      chk(mem[p] == g, "R9 single store data", mem[p], g);
      chk(n_wr - w0 == 1, "R9 one write", n_wr - w0, 1);
      chk(n_en - e0 == 1, "R7 enable before write", n_en - e0, 1);
    end

    // R7: full store
    for (int r = 1; r <= 5; r++) wr_reg(3'(r), 16'($urandom));
    e0 = n_en; w0 = n_wr;
    wr_reg(3'd0, 16'h0002);
    wait_idle(n);
    s = {strap, 2'b00};
    chk(mem[s] == cfg, "R7 store cfg", mem[s], cfg);
    chk(mem[s+1] == base, "R7 store base", mem[s+1], base);
    chk({mem[34], mem[33], mem[32]} == mac, "R7 store mac", {mem[34], mem[33], mem[32]}, mac);
    chk(n_wr - w0 == 5, "R7 write count", n_wr - w0, 5);
    chk(n_en - e0 == 5, "R7 enable count", n_en - e0, 5);
    chk(bad_wr == 0, "R7 write without enable", bad_wr, 0);
    chk(wait_err == 0 && n_wgap > 0, "R7 post-write wait", wait_err, 0);

    // R10: both bits -> reload
    mem[s] = ~cfg;
    w0 = n_wr;
    wr_reg(3'd0, 16'h0003);
    wait_idle(n);
    chk(cfg == mem[s], "R10 reload wins", cfg, mem[s]);
    chk(n_wr == w0, "R10 no write", n_wr - w0, 0);

    // R11
    wr_reg(3'd0, 16'h0004);
    rd_reg(3'd0, v);
    chk(v == 16'h0004, "R11 mode bit readback", v, 16'h0004);
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd0, v);
    chk(v == 16'h0000, "R11 mode bit cleared", v, 0);

    chk(bad_start == 0, "R2 start bit", bad_start, 0);
    chk(sk_err == 0 && n_phase > 0, "R3 sk phase width", sk_err, 0);
    chk(gap_err == 0, "R3 cs gap", gap_err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule